// File: doc/BRIEF.md
# Memory-Accumulated Large-Integer Multiplier

This block multiplies two unsigned integers of `NBLK` blocks of `BASE_W` bits each. Before a run, the operand blocks are written one per cycle through a small load port. They land in four storage banks, split by operand and by block-index parity. A start pulse begins the run. Each cycle, the block multiplies the adjacent A block pair (2k, 2k+1) by one B block j, and adds the two results into a column memory at addresses 2k+j and 2k+j+1. Because these two addresses always have opposite parity, the column memory is built as two banks, even and odd, that are updated in parallel.

Each column update is a read-modify-write: a registered read, then an add and a write-back. An update that hits the address written in the cycle before takes the pending sum from a bypass register instead of the stale read. Column sums are kept wide, and no carry moves between columns until every pair has been added in. Then the columns are read from lowest to highest. A running carry is folded in and the product leaves one `BASE_W`-bit word per cycle, lowest word first. Each entry is zeroed as it is read, so the memory is clean for the next run.

Top module: `mam_mult`

## Requirements
- R1: During and right after reset, `busy`, `out_valid` and `out_last` are 0.
- R2: A run streams the product A*B as 2*NBLK words. Word w carries product bits [w*BASE_W +: BASE_W], so word 0 is the least significant. Load encoding: `ld_b`=0 writes A, `ld_b`=1 writes B, and `ld_idx` is the block index, with block 0 the least significant.
- R3: The 2*NBLK words are valid in consecutive cycles. `out_last` is 1 only with the final word. `out_valid` is 0 in the cycle after the final word.
- R4: The first valid word appears NBLK*NBLK/2 + 4 clock edges after the edge that samples an accepted start.
- R5: Operands with every bit set give the exact product, so the widest column sums neither overflow nor lose a carry.
- R6: The column memory is empty after each run. A following run with a zero operand streams all-zero words.
- R7: While `busy` is 1, `ld_en` and `start` are ignored. The run in progress and the stored operands are unchanged.
- R8: Stored operands survive a run. Starting again without reloading gives the same product.
- R9: `busy` is 1 from the edge after an accepted start until the edge that raises `out_last`, at which it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write one operand block (only while idle) |
| ld_b | input | 1 | 0 selects operand A, 1 selects operand B |
| ld_idx | input | $clog2(NBLK) | Block index, 0 = least significant |
| ld_data | input | BASE_W | Block value |
| start | input | 1 | Begin a multiplication (only while idle) |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | `out_data` holds a product word |
| out_last | output | 1 | Final product word |
| out_data | output | BASE_W | Product word, least significant first |

## Verification
With the default of four blocks, the first product word is due 12 edges after the edge that accepts start: 8 pair cycles, 2 drain cycles, then the column read and the carry stage. The remaining seven words follow on the next seven edges. `busy` falls at the same edge as `out_last`. The bench drives and samples on the falling clock edge. It counts edges from the accepted start and requires the first word at exactly edge 12. Each later word is checked one edge apart, and `out_valid` must be low one edge after the last word.

// File: rtl/mam_pkg.sv
package mam_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MUL,
      ST_DRAIN,
      ST_OUT
   } mam_state_e;
endpackage

// File: rtl/mam_opbanks.sv
// Operand store: four banks split by operand and block-index parity.
// Bank 0: A even, bank 1: A odd, bank 2: B even, bank 3: B odd.
module mam_opbanks #(
   parameter int BASE_W = 16,
   parameter int NBLK   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      wr_b,
   input  logic [$clog2(NBLK)-1:0]   wr_idx,
   input  logic [BASE_W-1:0]         wr_data,
   input  logic [$clog2(NBLK/2)-1:0] rd_k,
   input  logic [$clog2(NBLK)-1:0]   rd_j,
   output logic [BASE_W-1:0]         a_lo,
   output logic [BASE_W-1:0]         a_hi,
   output logic [BASE_W-1:0]         b_sel
);
   localparam int HALF  = NBLK / 2;
   localparam int IDX_W = $clog2(NBLK);
   localparam int HW    = $clog2(HALF);

   logic [3:0][BASE_W-1:0] rd_w;
   logic [1:0]             wr_bank;

   assign wr_bank = {wr_b, wr_idx[0]};

   for (genvar g = 0; g < 4; g++) begin : g_bank
      logic [BASE_W-1:0] mem [HALF];
      logic [HW-1:0]     rix;

      if (g < 2) begin : g_ra
         assign rix = rd_k;
      end else begin : g_rb
         assign rix = rd_j[IDX_W-1:1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int e = 0; e < HALF; e++) mem[e] <= '0;
         end else if (wr_en && wr_bank == 2'(g)) begin
            mem[wr_idx[IDX_W-1:1]] <= wr_data;
         end
      end

      assign rd_w[g] = mem[rix];
   end

   assign a_lo  = rd_w[0];
   assign a_hi  = rd_w[1];
   assign b_sel = rd_j[0] ? rd_w[3] : rd_w[2];
endmodule

// File: rtl/mam_pairmul.sv
// Two parallel block multipliers with a registered output stage.
module mam_pairmul #(
   parameter int BASE_W = 16,
   parameter int AW     = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_v,
   input  logic [BASE_W-1:0]            a_lo,
   input  logic [BASE_W-1:0]            a_hi,
   input  logic [BASE_W-1:0]            b_in,
   input  logic [AW-1:0]                base_in,
   output logic                         out_v,
   output logic [1:0][2*BASE_W-1:0]     prod,
   output logic [AW-1:0]                base_out
);
   localparam int PW = 2 * BASE_W;

   logic [1:0][BASE_W-1:0] a_pair;
   assign a_pair = {a_hi, a_lo};

   for (genvar g = 0; g < 2; g++) begin : g_mul
      logic [PW-1:0] p_q;
      always_ff @(posedge clk) begin
         if (!rst_n)    p_q <= '0;
         else if (in_v) p_q <= PW'(a_pair[g]) * PW'(b_in);
      end
      assign prod[g] = p_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_v    <= 1'b0;
         base_out <= '0;
      end else begin
         out_v <= in_v;
         if (in_v) base_out <= base_in;
      end
   end
endmodule

// File: rtl/mam_accbank.sv
// One column-memory bank: registered read, add, write-back, one-entry bypass.
// The streaming port reads an entry and zeroes it on the same edge.
module mam_accbank #(
   parameter int ACC_W = 37,
   parameter int DEPTH = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     upd_v,
   input  logic [$clog2(DEPTH)-1:0] upd_addr,
   input  logic [ACC_W-1:0]         upd_val,
   input  logic                     drain_rd,
   input  logic [$clog2(DEPTH)-1:0] drain_addr,
   output logic [ACC_W-1:0]         rd_data
);
   localparam int LW = $clog2(DEPTH);

   logic [ACC_W-1:0] mem [DEPTH];
   logic [ACC_W-1:0] rd_q;
   logic [LW-1:0]    rd_addr;
   logic             s2_v;
   logic [LW-1:0]    s2_addr;
   logic [ACC_W-1:0] s2_val;
   logic             wb_v;
   logic [LW-1:0]    wb_addr;
   logic [ACC_W-1:0] wb_sum;
   logic [ACC_W-1:0] base_val;
   logic [ACC_W-1:0] sum;

   assign rd_addr  = drain_rd ? drain_addr : upd_addr;
   // The read for this update was taken before the previous write landed.
   assign base_val = (wb_v && wb_addr == s2_addr) ? wb_sum : rd_q;
   assign sum      = base_val + s2_val;
   assign rd_data  = rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
         rd_q    <= '0;
         s2_v    <= 1'b0;
         s2_addr <= '0;
         s2_val  <= '0;
         wb_v    <= 1'b0;
         wb_addr <= '0;
         wb_sum  <= '0;
      end else begin
         rd_q    <= mem[rd_addr];
         s2_v    <= upd_v;
         s2_addr <= upd_addr;
         s2_val  <= upd_val;
         wb_v    <= s2_v;
         wb_addr <= s2_addr;
         wb_sum  <= sum;
         if (s2_v)     mem[s2_addr]    <= sum;
         if (drain_rd) mem[drain_addr] <= '0;
      end
   end
endmodule

// File: rtl/mam_mult.sv
module mam_mult
   import mam_pkg::*;
#(
   parameter int BASE_W = 16,
   parameter int NBLK   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic                    ld_b,
   input  logic [$clog2(NBLK)-1:0] ld_idx,
   input  logic [BASE_W-1:0]       ld_data,
   input  logic                    start,
   output logic                    busy,
   output logic                    out_valid,
   output logic                    out_last,
   output logic [BASE_W-1:0]       out_data
);
   localparam int HALF   = NBLK / 2;
   localparam int IDX_W  = $clog2(NBLK);
   localparam int HW     = $clog2(HALF);
   localparam int AW     = IDX_W + 1;
   localparam int LW     = IDX_W;
   localparam int PW     = 2 * BASE_W;
   localparam int ACC_W  = PW + IDX_W + 1;
   localparam int CW     = ACC_W - BASE_W;
   localparam int LAST_M = 2 * NBLK - 1;

   if (NBLK < 4 || (NBLK % 2) != 0) begin : g_bad_nblk
      $error("NBLK must be even and at least 4");
   end
   if (BASE_W < 2) begin : g_bad_width
      $error("BASE_W must be at least 2");
   end

   mam_state_e        state;
   logic [HW-1:0]     k_q;
   logic [IDX_W-1:0]  j_q;
   logic              dcnt;
   logic [AW-1:0]     m_q;
   logic              accept;
   logic              issue;
   logic [AW-1:0]     base_addr;
   logic [BASE_W-1:0] a_lo, a_hi, b_sel;
   logic              s1_v;
   logic [1:0][PW-1:0] s1_prod;
   logic [AW-1:0]     s1_base;
   logic [1:0][ACC_W-1:0] col;
   logic              o1_v, o1_bank, o1_last, o1_first;
   logic [CW-1:0]     carry;
   logic [ACC_W-1:0]  tot;

   assign busy      = (state != ST_IDLE) || o1_v;
   assign accept    = start && !busy;
   assign issue     = (state == ST_MUL);
   assign base_addr = AW'({k_q, 1'b0}) + AW'(j_q);

   mam_opbanks #(.BASE_W(BASE_W), .NBLK(NBLK)) u_ops (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ld_en && !busy), .wr_b(ld_b), .wr_idx(ld_idx), .wr_data(ld_data),
      .rd_k(k_q), .rd_j(j_q),
      .a_lo(a_lo), .a_hi(a_hi), .b_sel(b_sel)
   );

   mam_pairmul #(.BASE_W(BASE_W), .AW(AW)) u_mul (
      .clk(clk), .rst_n(rst_n), .in_v(issue),
      .a_lo(a_lo), .a_hi(a_hi), .b_in(b_sel), .base_in(base_addr),
      .out_v(s1_v), .prod(s1_prod), .base_out(s1_base)
   );

   // Product 0 goes to column base, product 1 to base+1: opposite parities.
   for (genvar g = 0; g < 2; g++) begin : g_acc
      logic             own0;
      logic [ACC_W-1:0] u_val;
      logic [LW-1:0]    u_addr;
      assign own0   = (s1_base[0] == 1'(g));
      assign u_val  = own0 ? ACC_W'(s1_prod[0]) : ACC_W'(s1_prod[1]);
      assign u_addr = own0 ? s1_base[AW-1:1] : s1_base[AW-1:1] + LW'(s1_base[0]);

      mam_accbank #(.ACC_W(ACC_W), .DEPTH(NBLK)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .upd_v(s1_v), .upd_addr(u_addr), .upd_val(u_val),
         .drain_rd(state == ST_OUT && m_q[0] == 1'(g)),
         .drain_addr(m_q[AW-1:1]),
         .rd_data(col[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         k_q   <= '0;
         j_q   <= '0;
         dcnt  <= 1'b0;
         m_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept) state <= ST_MUL;
            ST_MUL: begin
               if (j_q == IDX_W'(NBLK - 1)) begin
                  j_q <= '0;
                  if (k_q == HW'(HALF - 1)) begin
                     k_q   <= '0;
                     state <= ST_DRAIN;
                  end else begin
                     k_q <= k_q + 1'b1;
                  end
               end else begin
                  j_q <= j_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               dcnt <= ~dcnt;
               if (dcnt) state <= ST_OUT;
            end
            ST_OUT: begin
               if (m_q == AW'(LAST_M)) begin
                  m_q   <= '0;
                  state <= ST_IDLE;
               end else begin
                  m_q <= m_q + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign tot = (o1_bank ? col[1] : col[0]) + (o1_first ? '0 : ACC_W'(carry));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o1_v      <= 1'b0;
         o1_bank   <= 1'b0;
         o1_last   <= 1'b0;
         o1_first  <= 1'b0;
         carry     <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         o1_v      <= (state == ST_OUT);
         o1_bank   <= m_q[0];
         o1_last   <= (m_q == AW'(LAST_M));
         o1_first  <= (m_q == '0);
         out_valid <= o1_v;
         out_last  <= o1_v && o1_last;
         if (o1_v) begin
            out_data <= tot[BASE_W-1:0];
            carry    <= tot[ACC_W-1:BASE_W];
         end
      end
   end
endmodule

// File: rtl/mam_chk.sv
module mam_chk #(
   parameter int NBLK = 4
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic out_valid,
   input logic out_last
);
   localparam int LAT = NBLK * NBLK / 2 + 4;
   localparam int NW  = 2 * NBLK;

   int unsigned lat_cnt;
   int unsigned w_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_cnt <= 0;
         w_cnt   <= 0;
      end else begin
         if (start && !busy)                 lat_cnt <= 1;
         else if (out_valid)                 lat_cnt <= 0;
         else if (lat_cnt != 0)              lat_cnt <= lat_cnt + 1;
         if (out_valid) w_cnt <= out_last ? 0 : w_cnt + 1;
      end
   end

   p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   p_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |=> out_valid);

   p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> w_cnt == NW - 1);

   // lat_cnt counts the accept edge as 1, so the first word shows at LAT+1.
   p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> lat_cnt == LAT + 1);

   p_busy_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_last |-> busy);

   p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);
endmodule

bind mam_mult mam_chk #(.NBLK(NBLK)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
   .out_valid(out_valid), .out_last(out_last)
);

// File: tb/sim_mam_mult.sv
module sim_mam_mult;
   localparam int B   = 16;
   localparam int N   = 4;
   localparam int NW  = 2 * N;
   localparam int LAT = N * N / 2 + 4;
   localparam int NV  = 5;

   localparam logic [63:0] TV_A [NV] = '{
      64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
      64'hDEAD_BEEF_0BAD_F00D, 64'h0000_FFFF_0000_FFFF };
   localparam logic [63:0] TV_B [NV] = '{
      64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002,
      64'h1357_9BDF_2468_ACE0, 64'hFFFF_0000_FFFF_0000 };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld_en = 1'b0;
   logic         ld_b = 1'b0;
   logic [1:0]   ld_idx = '0;
   logic [B-1:0] ld_data = '0;
   logic         start = 1'b0;
   logic         busy, out_valid, out_last;
   logic [B-1:0] out_data;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   mam_mult #(.BASE_W(B), .NBLK(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_b(ld_b), .ld_idx(ld_idx),
      .ld_data(ld_data), .start(start), .busy(busy), .out_valid(out_valid),
      .out_last(out_last), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [63:0] a, input logic [63:0] b);
      for (int i = 0; i < 2 * N; i++) begin
         @(negedge clk);
         ld_en   = 1'b1;
         ld_b    = (i >= N);
         ld_idx  = 2'(i % N);
         ld_data = (i >= N) ? b[(i % N) * B +: B] : a[i * B +: B];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_case(input logic [63:0] ea, input logic [63:0] eb,
                           input bit noisy, input string req);
      logic [127:0] exp_p;
      int cyc;
      exp_p = {64'd0, ea} * {64'd0, eb};
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      chk(busy == 1'b1, "R9 busy after start", 128'(busy), 128'(1));
      while (!out_valid && cyc < 64) begin
         if (noisy) begin
            ld_en   = 1'b1;
            ld_b    = cyc[0];
            ld_idx  = 2'(cyc);
            ld_data = B'(16'hA5A5 ^ cyc);
            start   = 1'b1;
         end
         @(negedge clk);
         cyc++;
      end
      ld_en = 1'b0;
      start = 1'b0;
      chk(cyc == LAT, "R4 first word latency", 128'(cyc), 128'(LAT));
      for (int w = 0; w < NW; w++) begin
         chk(out_valid == 1'b1, "R3 valid run", 128'(out_valid), 128'(1));
         chk(out_data == exp_p[w * B +: B], req, 128'(out_data), 128'(exp_p[w * B +: B]));
         chk(out_last == (w == NW - 1), "R3 last flag", 128'(out_last), 128'(w == NW - 1));
         if (w == NW - 1)
            chk(busy == 1'b0, "R9 busy falls with last", 128'(busy), 128'(0));
         @(negedge clk);
      end
      chk(out_valid == 1'b0, "R3 valid drops", 128'(out_valid), 128'(0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R1 in reset",
          128'({busy, out_valid, out_last}), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R1 after reset",
          128'({busy, out_valid, out_last}), 128'(0));

      // Table walk: R2 general products, R5 for the all-ones entry.
      for (int v = 0; v < NV; v++) begin
         load(TV_A[v], TV_B[v]);
         run_case(TV_A[v], TV_B[v], 1'b0, (v == 1) ? "R5 all-ones word" : "R2 product word");
      end

      // R8: rerun without reloading.
      run_case(TV_A[NV-1], TV_B[NV-1], 1'b0, "R8 retained operands");

      // R7: loads and start pulses during a run are ignored.
      load(TV_A[3], TV_B[3]);
      run_case(TV_A[3], TV_B[3], 1'b1, "R7 run with noise");
      run_case(TV_A[3], TV_B[3], 1'b0, "R7 operands untouched");

      // R6: memory emptied, zero operand gives zero.
      load(64'd0, TV_B[3]);
      run_case(64'd0, TV_B[3], 1'b0, "R6 zero after run");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule